// File: doc/BRIEF.md
# Byte-Serial AES State Datapath

This block holds the 128-bit AES data state as a grid of four rows by four columns of bytes and processes it one byte per clock. All arithmetic takes place on the rightmost column. Every row can rotate left by one column per cycle, and the rightmost column can shift upward by one row per cycle. An external sequencer drives a small operation code each cycle and selects which rows rotate. From this the block builds loading, ShiftRows and its inverse, MixColumns (serial, through a sum register and a buffer register), AddRoundKey and output streaming. The inverse MixColumns is three forward passes. The substitution box is not inside the block. The byte in row 0 of the rightmost column is always presented on a port, and the substituted byte comes back on another port in the same cycle.

State byte `i` of the AES block sits in column `i/4`, row `i%4`. Because of this, four loads followed by a full-row rotate place consecutive 32-bit words in consecutive columns. Round-key bytes arrive on their own 8-bit input and are added only in cycles where the sequencer enables them.

Top module: `aes_serial_state`

## Requirements
- R1: Operation code 1 (load) writes `dataIn` into row 3 of the rightmost column and moves every other byte of that column up one row. After four loads, the first byte loaded is in row 0 and appears on `sboxByte`.
- R2: Operation code 2 (rotate) rotates each row whose `rowMask` bit is set (bit r for row r) left by one column, so that column c takes column c+1 and column 3 takes column 0. Rows whose bit is clear keep their contents. ShiftRows is three rotates with masks 4'b1110, 4'b1100 and 4'b1000.
- R3: Inverse ShiftRows is three rotates with the row 1 and row 3 enables exchanged: masks 4'b1110, 4'b0110 and 4'b0010.
- R4: Operation code 4 (mix start) stores the XOR of the four rightmost-column bytes in the sum register and copies row 0 into the buffer register. Each operation code 5 (mix step) then loads the buffer with 3·row0 ⊕ 2·row1 ⊕ sum, shifts the column up, and places the old buffer value in row 3. After one start and five steps, the column holds its MixColumns image. Doubling is a one-bit left shift, XORed with 0x1B when the bit shifted out was 1.
- R5: Whenever the buffer value moves into row 3, `keyIn` is XORed into it if `keyEn` is 1. When `keyEn` is 0, `keyIn` has no effect.
- R6: With `lastRound` at 1, a mix step loads the buffer with row 0 unchanged. This turns the six-cycle sequence into a pure AddRoundKey on the column.
- R7: Operation code 3 (substitute) with `invMode` 0 shifts the column up and writes `sboxIn` into row 3.
- R8: Operation code 3 with `invMode` 1 writes `sboxIn` into the buffer and shifts the column up, with the old buffer value (plus the key, if enabled) entering row 3.
- R9: Three successive mix passes on a column give inverse MixColumns. With R3 and R8 this decrypts a block from its last round key.
- R10: `dataOut` is registered. After an operation code 6 (drain) cycle, it shows the row-0 byte from before that edge, and the column shifts up with row 0 wrapping into row 3. After any other code it is zero.
- R11: Operation codes 0 and 7 leave the state, buffer and sum unchanged.
- R12: An active-low asynchronous `rstN` clears the state, both registers and `dataOut` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Operation for this cycle |
| rowMask | input | 4 | Per-row rotate enables for operation code 2 |
| invMode | input | 1 | Selects the decryption path for substitution |
| lastRound | input | 1 | Bypasses MixColumns in mix steps |
| keyEn | input | 1 | Gates the round-key byte |
| dataIn | input | 8 | Byte being loaded |
| keyIn | input | 8 | Round-key byte |
| sboxIn | input | 8 | Substituted byte returned by the external S-box |
| sboxByte | output | 8 | Row 0 of the rightmost column, sent to the S-box |
| dataOut | output | 8 | Gated result byte |

## Verification
Two things can happen in the same edge: a new value is written into the buffer (a MixColumns product, or an S-box result during decryption), and the previous buffer value is key-added into row 3. The bench provokes this by raising `keyEn` on the last four mix steps of every round and on the later substitution cycles of decryption. It also drives noise on `keyIn` whenever `keyEn` is low. The result is judged on every cycle by a behavioural model of the column and the two registers. It is also judged end to end by encrypting and decrypting a known AES-128 vector, whose result shows any slip in the order of the two writes.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int BW = 8;
  localparam int NR = 4;
  localparam int NC = 4;
  localparam int OPW = 3;
  localparam logic [BW-1:0] REDUCE = 8'h1B;

  typedef logic [BW-1:0] byte_t;

  typedef enum logic [OPW-1:0] {
    OP_IDLE     = 3'd0,
    OP_LOAD     = 3'd1,
    OP_ROT      = 3'd2,
    OP_SUB      = 3'd3,
    OP_MIXSTART = 3'd4,
    OP_MIXSTEP  = 3'd5,
    OP_DRAIN    = 3'd6
  } op_e;

  typedef enum logic [1:0] {SRC_IN, SRC_SBOX, SRC_MB, SRC_WRAP} src_e;
  typedef enum logic [1:0] {MB_ROW0, MB_MIX, MB_SBOX} mbsel_e;

  typedef struct packed {
    logic          colUp;
    logic [NR-1:0] rowRot;
    src_e          src15;
    logic          mbLoad;
    mbsel_e        mbSel;
    logic          msLoad;
    logic          keyOn;
    logic          outOn;
  } strobe_t;

  function automatic byte_t xtime(byte_t v);
    return {v[BW-2:0], 1'b0} ^ (v[BW-1] ? REDUCE : '0);
  endfunction

  function automatic byte_t mul3(byte_t v);
    return xtime(v) ^ v;
  endfunction
endpackage

// File: rtl/aes_col_ctrl.sv
module aes_col_ctrl
  import aes_col_pkg::*;
(
  input  logic [OPW-1:0] opCode,
  input  logic [NR-1:0]  rowMask,
  input  logic           invMode,
  input  logic           lastRound,
  input  logic           keyEn,
  output strobe_t        stb
);
  always_comb begin
    stb        = '0;
    stb.src15  = SRC_IN;
    stb.mbSel  = MB_ROW0;
    case (op_e'(opCode))
      OP_LOAD: begin
        stb.colUp = 1'b1;
        stb.src15 = SRC_IN;
      end
      OP_ROT: stb.rowRot = rowMask;
      OP_SUB: begin
        stb.colUp = 1'b1;
        if (invMode) begin
          stb.src15  = SRC_MB;
          stb.mbLoad = 1'b1;
          stb.mbSel  = MB_SBOX;
          stb.keyOn  = keyEn;
        end else begin
          stb.src15 = SRC_SBOX;
        end
      end
      OP_MIXSTART: begin
        stb.msLoad = 1'b1;
        stb.mbLoad = 1'b1;
        stb.mbSel  = MB_ROW0;
      end
      OP_MIXSTEP: begin
        stb.colUp  = 1'b1;
        stb.src15  = SRC_MB;
        stb.mbLoad = 1'b1;
        stb.mbSel  = lastRound ? MB_ROW0 : MB_MIX;
        stb.keyOn  = keyEn;
      end
      OP_DRAIN: begin
        stb.colUp = 1'b1;
        stb.src15 = SRC_WRAP;
        stb.outOn = 1'b1;
      end
      default: stb.colUp = 1'b0;
    endcase
  end
endmodule

// File: rtl/aes_col_dp.sv
module aes_col_dp
  import aes_col_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  byte_t   dataIn,
  input  byte_t   keyIn,
  input  byte_t   sboxIn,
  output byte_t   sboxByte,
  output byte_t   dataOut
);
  localparam int ROW_W = NC * BW;
  localparam int TOP   = (NC - 1) * BW;
  localparam int ALL_W = NR * ROW_W;

  logic [ALL_W-1:0] stateQ, stateNxt;
  byte_t colByte [NR];
  byte_t mbQ, msQ, mbNxt, feed15, keyGated, mixVal, colSum;

  assign keyGated = keyIn & {BW{stb.keyOn}};

  always_comb begin
    case (stb.src15)
      SRC_IN:   feed15 = dataIn;
      SRC_SBOX: feed15 = sboxIn;
      SRC_MB:   feed15 = mbQ ^ keyGated;
      default:  feed15 = colByte[0];
    endcase
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_row
      localparam int BASE = r * ROW_W;
      byte_t upByte;
      assign colByte[r] = stateQ[BASE+TOP +: BW];
      if (r == NR - 1) begin : g_bottom
        assign upByte = feed15;
      end else begin : g_upper
        assign upByte = stateQ[BASE+ROW_W+TOP +: BW];
      end
      assign stateNxt[BASE +: ROW_W] =
        stb.colUp      ? {upByte, stateQ[BASE +: TOP]} :
        stb.rowRot[r]  ? {stateQ[BASE +: BW], stateQ[BASE+BW +: TOP]} :
                         stateQ[BASE +: ROW_W];
    end
  endgenerate

  always_comb begin
    colSum = '0;
    for (int r = 0; r < NR; r++) colSum ^= colByte[r];
  end

  assign mixVal = mul3(colByte[0]) ^ xtime(colByte[1]) ^ msQ;

  always_comb begin
    case (stb.mbSel)
      MB_MIX:  mbNxt = mixVal;
      MB_SBOX: mbNxt = sboxIn;
      default: mbNxt = colByte[0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= '0;
      mbQ     <= '0;
      msQ     <= '0;
      dataOut <= '0;
    end else begin
      stateQ  <= stateNxt;
      if (stb.mbLoad) mbQ <= mbNxt;
      if (stb.msLoad) msQ <= colSum;
      dataOut <= stb.outOn ? colByte[0] : '0;
    end
  end

  assign sboxByte = colByte[0];
endmodule

// File: rtl/aes_serial_state.sv
module aes_serial_state
  import aes_col_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [OPW-1:0] opCode,
  input  logic [NR-1:0]  rowMask,
  input  logic           invMode,
  input  logic           lastRound,
  input  logic           keyEn,
  input  logic [BW-1:0]  dataIn,
  input  logic [BW-1:0]  keyIn,
  input  logic [BW-1:0]  sboxIn,
  output logic [BW-1:0]  sboxByte,
  output logic [BW-1:0]  dataOut
);
  strobe_t stb;

  aes_col_ctrl u_ctrl (
    .opCode    (opCode),
    .rowMask   (rowMask),
    .invMode   (invMode),
    .lastRound (lastRound),
    .keyEn     (keyEn),
    .stb       (stb)
  );

  aes_col_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dataIn   (dataIn),
    .keyIn    (keyIn),
    .sboxIn   (sboxIn),
    .sboxByte (sboxByte),
    .dataOut  (dataOut)
  );
endmodule

// File: rtl/aes_col_chk.sv
module aes_col_chk
  import aes_col_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic [OPW-1:0] opCode,
  input logic           row0Rot,
  input logic [BW-1:0]  dataIn,
  input logic [BW-1:0]  sboxByte,
  input logic [BW-1:0]  dataOut
);
  logic [2:0] sinceRst;
  logic       histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end
  assign histOk = (sinceRst >= 3'd5);

  assert_out_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != OP_DRAIN) |=> (dataOut == '0));

  assert_drain_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_DRAIN) |=> (dataOut == $past(sboxByte)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_IDLE) |=> $stable(sboxByte));

  assert_row0_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ROT && !row0Rot) |=> $stable(sboxByte));

  assert_load_depth_R1: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && opCode == OP_LOAD && $past(opCode) == OP_LOAD &&
     $past(opCode, 2) == OP_LOAD && $past(opCode, 3) == OP_LOAD)
    |=> (sboxByte == $past(dataIn, 4)));
endmodule

bind aes_serial_state aes_col_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opCode   (opCode),
  .row0Rot  (rowMask[0]),
  .dataIn   (dataIn),
  .sboxByte (sboxByte),
  .dataOut  (dataOut)
);

// File: tb/sim_aes_serial_state.sv
`timescale 1ns/1ps
module sim_aes_serial_state;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] opCode;
  logic [3:0] rowMask;
  logic       invMode, lastRound, keyEn;
  logic [7:0] dataIn, keyIn, sboxIn, sboxByte, dataOut;

  always #2.5 clk = ~clk;

  aes_serial_state u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .rowMask(rowMask),
    .invMode(invMode), .lastRound(lastRound), .keyEn(keyEn),
    .dataIn(dataIn), .keyIn(keyIn), .sboxIn(sboxIn),
    .sboxByte(sboxByte), .dataOut(dataOut)
  );

  int total = 0;
  int bad = 0;
  int sb [256];
  int isb [256];
  int kb [176];
  int m [4][4];
  int mMb, mMs, mOut;
  int prevOp;
  string prevTag;
  int outQ[$];

  assign sboxIn = 8'(invMode ? isb[sboxByte] : sb[sboxByte]);

  function automatic int dbl(int x);
    return ((x << 1) ^ (((x & 128) != 0) ? 27 : 0)) & 255;
  endfunction

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p ^= a;
      a = dbl(a);
    end
    return p;
  endfunction

  function automatic int calcSbox(int x);
    int inv = 1;
    int r;
    for (int i = 0; i < 254; i++) inv = gmul(inv, x);
    if (x == 0) inv = 0;
    r = inv;
    for (int k = 1; k < 5; k++) r ^= ((inv << k) | (inv >> (8 - k))) & 255;
    return r ^ 8'h63;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic string tagOf(int op);
    case (op)
      1: return "R1 load";
      2: return invMode ? "R3 rotate" : "R2 rotate";
      3: return invMode ? "R8 substitute" : "R7 substitute";
      4: return "R4 mix start";
      5: return lastRound ? "R6 R5 bypass step" : "R4 R5 mix step";
      6: return "R10 drain";
      default: return "R11 idle";
    endcase
  endfunction

  task automatic colUp(int v);
    for (int r = 0; r < 3; r++) m[r][3] = m[r+1][3];
    m[3][3] = v;
  endtask

  // One cycle: compare the result of the previous cycle, drive, update the model.
  task automatic cyc(int op, int mask, int din, int key, bit ken, bit last);
    int c0, c1, s, kg, nv, t;
    @(negedge clk);
    chk({prevTag, " byte"}, sboxByte, m[0][3]);
    chk({prevTag, " out"}, dataOut, mOut);
    if (prevOp == 6) outQ.push_back(dataOut);
    opCode = 3'(op); rowMask = 4'(mask); lastRound = last; keyEn = ken;
    dataIn = 8'(din);
    keyIn = ken ? 8'(key) : 8'(din ^ 8'hA5 ^ op);
    kg = ken ? key : 0;
    c0 = m[0][3]; c1 = m[1][3];
    mOut = 0;
    case (op)
      1: colUp(din);
      2: for (int r = 0; r < 4; r++)
           if ((mask >> r) & 1) begin
             t = m[r][0];
             for (int c = 0; c < 3; c++) m[r][c] = m[r][c+1];
             m[r][3] = t;
           end
      3: begin
        s = invMode ? isb[c0] : sb[c0];
        if (invMode) begin colUp(mMb ^ kg); mMb = s; end
        else colUp(s);
      end
      4: begin mMs = m[0][3] ^ m[1][3] ^ m[2][3] ^ m[3][3]; mMb = c0; end
      5: begin
        nv = last ? c0 : (dbl(c0) ^ c0 ^ dbl(c1) ^ mMs);
        colUp(mMb ^ kg);
        mMb = nv;
      end
      6: begin mOut = c0; colUp(c0); end
      default: ;
    endcase
    prevOp = op;
    prevTag = tagOf(op);
  endtask

  task automatic loadBlock(int blk[16]);
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) cyc(1, 0, blk[4*c+r], 0, 0, 0);
      if (c < 3) cyc(2, 4'b1111, 0, 0, 0, 0);
    end
  endtask

  task automatic addKeyOnly(int rd);
    for (int c = 0; c < 4; c++) begin
      cyc(2, 4'b1111, 0, 0, 0, 0);
      cyc(4, 0, 0, 0, 0, 0);
      for (int s = 0; s < 5; s++)
        cyc(5, 0, 0, (s > 0) ? kb[16*rd + 4*c + s - 1] : 0, s > 0, 1);
    end
  endtask

  task automatic drainBlock();
    outQ.delete();
    for (int c = 0; c < 4; c++) begin
      cyc(2, 4'b1111, 0, 0, 0, 0);
      for (int r = 0; r < 4; r++) cyc(6, 0, 0, 0, 0, 0);
    end
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic encrypt(int pt[16]);
    invMode = 0;
    loadBlock(pt);
    addKeyOnly(0);
    for (int rd = 1; rd <= 10; rd++) begin
      cyc(2, 4'b1110, 0, 0, 0, 0);
      cyc(2, 4'b1100, 0, 0, 0, 0);
      cyc(2, 4'b1000, 0, 0, 0, 0);
      for (int c = 0; c < 4; c++) begin
        cyc(2, 4'b1111, 0, 0, 0, 0);
        for (int s = 0; s < 4; s++) cyc(3, 0, 0, 0, 0, 0);
        cyc(4, 0, 0, 0, 0, 0);
        for (int s = 0; s < 5; s++)
          cyc(5, 0, 0, (s > 0) ? kb[16*rd + 4*c + s - 1] : 0, s > 0, rd == 10);
      end
    end
    drainBlock();
  endtask

  task automatic decrypt(int ct[16]);
    invMode = 1;
    loadBlock(ct);
    addKeyOnly(10);
    for (int rd = 9; rd >= 0; rd--) begin
      cyc(2, 4'b1110, 0, 0, 0, 0);
      cyc(2, 4'b0110, 0, 0, 0, 0);
      cyc(2, 4'b0010, 0, 0, 0, 0);
      for (int c = 0; c < 4; c++) begin
        cyc(2, 4'b1111, 0, 0, 0, 0);
        for (int s = 0; s < 4; s++)
          cyc(3, 0, 0, (s > 0) ? kb[16*rd + 4*c + s - 1] : 0, s > 0, 0);
        cyc(5, 0, 0, kb[16*rd + 4*c + 3], 1, 1);
        if (rd > 0)
          for (int p = 0; p < 3; p++) begin
            cyc(4, 0, 0, 0, 0, 0);
            for (int s = 0; s < 5; s++) cyc(5, 0, 0, 0, 0, 0);
          end
      end
    end
    drainBlock();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pt[16];
    int ct[16];
    int key[16];
    int t[4];
    int rc, tmp;
    for (int i = 0; i < 256; i++) sb[i] = calcSbox(i);
    for (int i = 0; i < 256; i++) isb[sb[i]] = i;
    for (int i = 0; i < 16; i++) begin
      pt[i] = (i << 4) | i;
      key[i] = i;
      kb[i] = i;
    end
    ct = '{8'h69, 8'hc4, 8'he0, 8'hd8, 8'h6a, 8'h7b, 8'h04, 8'h30,
           8'hd8, 8'hcd, 8'hb7, 8'h80, 8'h70, 8'hb4, 8'hc5, 8'h5a};
    rc = 1;
    for (int i = 16; i < 176; i += 4) begin
      for (int j = 0; j < 4; j++) t[j] = kb[i-4+j];
      if (i % 16 == 0) begin
        tmp = t[0];
        t[0] = sb[t[1]] ^ rc; t[1] = sb[t[2]]; t[2] = sb[t[3]]; t[3] = sb[tmp];
        rc = dbl(rc);
      end
      for (int j = 0; j < 4; j++) kb[i+j] = kb[i-16+j] ^ t[j];
    end
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = 0;
    mMb = 0; mMs = 0; mOut = 0; prevOp = 0; prevTag = "R12 reset";
    rstN = 0; opCode = 0; rowMask = 0; invMode = 0; lastRound = 0;
    keyEn = 0; dataIn = 0; keyIn = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R12 reset out", dataOut, 0);
    chk("R12 reset byte", sboxByte, 0);
    rstN = 1;

    // R1 R11 R2: load a pattern, idle with noise, rotate with row 0 masked off
    for (int r = 0; r < 4; r++) cyc(1, 0, 8'h10 + r, 0, 0, 0);
    cyc(0, 0, 8'hEE, 0, 0, 0);
    cyc(7, 0, 8'hEF, 0, 0, 0);
    cyc(2, 4'b1110, 0, 0, 0, 0);
    cyc(2, 4'b0000, 0, 0, 0, 0);
    // R4: one column through mix start and five steps, no key
    cyc(4, 0, 0, 0, 0, 0);
    for (int s = 0; s < 5; s++) cyc(5, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    encrypt(pt);
    chk("R4 R7 R2 encrypt length", outQ.size(), 16);
    for (int i = 0; i < 16 && i < outQ.size(); i++)
      chk("R4 R5 R6 R7 encrypt vector", outQ[i], ct[i]);

    decrypt(ct);
    chk("R9 R8 R3 decrypt length", outQ.size(), 16);
    for (int i = 0; i < 16 && i < outQ.size(); i++)
      chk("R9 R8 R3 decrypt vector", outQ[i], pt[i]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule